// File: doc/BRIEF.md
# Radio PHY Mode Control Register with Receive-Buffer Lock

This block keeps an eight-bit transceiver configuration register. It turns that register into the physical-layer settings that the modem needs: modulation, chip rate, payload data rate, pulse shaping, use of the alternative spreading code, chip scrambling, and a flag that marks the setting as legal. Software writes the register through a plain write strobe and reads it back on a parallel read bus. The decoded settings come out of flip-flops one clock after the register changes.

The block also runs a receive-buffer lock. When the safe-receive bit is set, the first frame that arrives with a good frame check locks the buffer, and later frames must leave it alone. The lock opens again in three cases: the active-low serial select line rises at the end of a buffer read, the transceiver leaves one of its listening states, or software clears the safe-receive bit.

Top module: `phy_mode_ctrl`

## Requirements
- R1: Synchronous active-high reset loads the register with 0x14 and opens the lock. In the first cycle after reset the outputs show the 0x14 setting: BPSK, 600 kchip/s, 40 kb/s, mode valid.
- R2: A cycle with `cfg_wr` high stores `cfg_wdata`, and `cfg_rdata` shows all eight bits from the next cycle. Field positions: bit 7 safe-receive, bit 6 regulator hold, bit 5 scrambler request, bit 4 alternative spectrum, bit 3 O-QPSK select (0 = BPSK), bit 2 high sub-band, bits 1:0 rate code. The decoded outputs follow the stored value one cycle later.
- R3: `chip_kcps` is 1000 for O-QPSK with the high sub-band and 400 with the low one. For BPSK it is 600 with the high sub-band and 300 with the low one.
- R4: For O-QPSK, rate codes 0, 1, 2, 3 give `rate_kbps` of 250, 500, 1000, 500 with the high sub-band. With the low sub-band they give 100, 200, 400 and 0. For BPSK, `rate_kbps` is 40 with the high sub-band and 20 with the low one, whatever the rate code.
- R5: `mode_ok` is low only for O-QPSK with the low sub-band and rate code 3. It is high for every other value.
- R6: `scram_on` is high only when the scrambler request is set, O-QPSK is selected and the rate code is 2 (400 or 1000 kb/s).
- R7: `shape_sel` is 0 for BPSK. For O-QPSK with the high sub-band it is 1 (half-sine) or 2 (RC-0.8). For O-QPSK with the low sub-band it is 3 (half-sine plus RC-0.2) or 4 (RC-0.2). The alternative spectrum bit picks the second value in each pair. `alt_spread` equals that bit under BPSK and is 0 under O-QPSK.
- R8: With safe-receive set, a cycle with `rx_frame_ok` high sets `buf_locked` from the next cycle. The lock stays set through further good frames. With safe-receive clear, frames never set the lock.
- R9: A rising edge of `spi_sel_n` clears the lock if `buf_read` is high in the cycle where `spi_sel_n` is first seen high. A rising edge without `buf_read` leaves the lock set.
- R10: The lock clears when `trx_state` moves from the listen code 0x06 or the listen-with-acknowledge code 0x16 to any other code.
- R11: While safe-receive is stored as 0, the lock is held clear. A clear event and a good frame in the same cycle leave the lock clear.
- R12: `reg_hold` follows bit 6 of the stored value, one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value |
| cfg_rdata | output | 8 | Stored register value |
| rx_frame_ok | input | 1 | One-cycle strobe: frame received with a good frame check |
| trx_state | input | 5 | Current transceiver state code |
| buf_read | input | 1 | A buffer read access is in progress |
| spi_sel_n | input | 1 | Active-low serial select line |
| is_oqpsk | output | 1 | 1 = O-QPSK, 0 = BPSK |
| chip_kcps | output | 11 | Chip rate in kchip/s |
| rate_kbps | output | 11 | Payload data rate in kb/s, 0 when reserved |
| shape_sel | output | 3 | Pulse-shaping code |
| alt_spread | output | 1 | BPSK alternative spreading sequence in use |
| scram_on | output | 1 | Chip scrambler active |
| mode_ok | output | 1 | Setting is not reserved |
| reg_hold | output | 1 | Keep the analog regulator on in the off state |
| buf_locked | output | 1 | Receive buffer is protected |

## Verification
Two things can happen to the lock in the same cycle: a good frame tries to set it while a clear event tries to open it. The bench sets this up in two ways. It raises the select line at the end of a read in the same cycle as a good frame, and it marks a frame good in the cycle where the state leaves a listen code. In both cases the lock must read clear on the next cycle. The same outcome holds when software clears safe-receive while frames keep arriving. A behavioural model runs beside the design and compares the lock and every decoded field on each clock.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;

  localparam int CFG_W  = 8;
  localparam int RATE_W = 11;

  localparam int B_SAFE  = 7;
  localparam int B_HOLD  = 6;
  localparam int B_SCRAM = 5;
  localparam int B_ALT   = 4;
  localparam int B_OQ    = 3;
  localparam int B_SUB   = 2;

  typedef enum logic [2:0] {
    SHP_NONE      = 3'd0,
    SHP_HALF_SINE = 3'd1,
    SHP_RC08      = 3'd2,
    SHP_SIN_RC02  = 3'd3,
    SHP_RC02      = 3'd4
  } shape_e;

  typedef struct packed {
    logic              oqpsk;
    logic [RATE_W-1:0] chip;
    logic [RATE_W-1:0] rate;
    shape_e            shape;
    logic              alt_spread;
    logic              scram;
    logic              valid;
    logic              hold;
  } mode_t;

  function automatic logic [RATE_W-1:0] oq_rate(input logic sub, input logic [1:0] code);
    logic [RATE_W-1:0] r;
    case (code)
      2'd0:    r = sub ? RATE_W'(250)  : RATE_W'(100);
      2'd1:    r = sub ? RATE_W'(500)  : RATE_W'(200);
      2'd2:    r = sub ? RATE_W'(1000) : RATE_W'(400);
      default: r = sub ? RATE_W'(500)  : RATE_W'(0);
    endcase
    return r;
  endfunction

  function automatic mode_t decode_cfg(input logic [CFG_W-1:0] c);
    mode_t m;
    logic  oq, sub, alt;
    oq  = c[B_OQ];
    sub = c[B_SUB];
    alt = c[B_ALT];
    m.oqpsk = oq;
    if (oq) m.chip = sub ? RATE_W'(1000) : RATE_W'(400);
    else    m.chip = sub ? RATE_W'(600)  : RATE_W'(300);
    if (oq) m.rate = oq_rate(sub, c[1:0]);
    else    m.rate = sub ? RATE_W'(40) : RATE_W'(20);
    if (!oq)     m.shape = SHP_NONE;
    else if (sub) m.shape = alt ? SHP_RC08 : SHP_HALF_SINE;
    else          m.shape = alt ? SHP_RC02 : SHP_SIN_RC02;
    m.alt_spread = alt && !oq;
    m.scram      = c[B_SCRAM] && oq && (c[1:0] == 2'd2);
    m.valid      = !(oq && !sub && (c[1:0] == 2'd3));
    m.hold       = c[B_HOLD];
    return m;
  endfunction

endpackage

// File: rtl/phy_cfg_reg.sv
module phy_cfg_reg #(
  parameter int                 W         = 8,
  parameter logic [W-1:0]       RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/phy_mode_decode.sv
module phy_mode_decode
  import phy_mode_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 8'h14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  output mode_t            mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= decode_cfg(RESET_VAL);
    else     mode_q <= decode_cfg(cfg);
  end
endmodule

// File: rtl/phy_buf_guard.sv
module phy_buf_guard #(
  parameter int                       STATE_W  = 5,
  parameter int                       N_RX     = 2,
  parameter logic [N_RX*STATE_W-1:0]  RX_CODES = {5'h16, 5'h06}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               safe_en,
  input  logic               frame_ok,
  input  logic [STATE_W-1:0] state,
  input  logic               rd_active,
  input  logic               sel_n,
  output logic               locked
);
  logic               sel_prev;
  logic [STATE_W-1:0] state_prev;
  logic [N_RX-1:0]    prev_hit;
  logic               sel_release, leave_rx, clear_evt;

  always_ff @(posedge clk) begin
    sel_prev   <= sel_n;
    state_prev <= state;
  end

  for (genvar i = 0; i < N_RX; i++) begin : g_rx_match
    assign prev_hit[i] = (state_prev == RX_CODES[i*STATE_W +: STATE_W]);
  end

  assign sel_release = sel_n && !sel_prev && rd_active;
  assign leave_rx    = (|prev_hit) && (state != state_prev);
  assign clear_evt   = sel_release || leave_rx || !safe_en;

  always_ff @(posedge clk) begin
    if (rst)                       locked <= 1'b0;
    else if (clear_evt)            locked <= 1'b0;
    else if (safe_en && frame_ok)  locked <= 1'b1;
  end
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int                 STATE_W      = 5,
  parameter logic [STATE_W-1:0] RX_ON_CODE   = 5'h06,
  parameter logic [STATE_W-1:0] RX_AACK_CODE = 5'h16,
  parameter logic [7:0]         RESET_VAL    = 8'h14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               rx_frame_ok,
  input  logic [STATE_W-1:0] trx_state,
  input  logic               buf_read,
  input  logic               spi_sel_n,
  output logic               is_oqpsk,
  output logic [10:0]        chip_kcps,
  output logic [10:0]        rate_kbps,
  output logic [2:0]         shape_sel,
  output logic               alt_spread,
  output logic               scram_on,
  output logic               mode_ok,
  output logic               reg_hold,
  output logic               buf_locked
);
  localparam int N_RX = 2;

  mode_t mode_q;

  phy_cfg_reg #(.W(CFG_W), .RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg_rdata)
  );

  phy_mode_decode #(.RESET_VAL(RESET_VAL)) u_dec (
    .clk(clk), .rst(rst), .cfg(cfg_rdata), .mode_q(mode_q)
  );

  phy_buf_guard #(
    .STATE_W(STATE_W), .N_RX(N_RX), .RX_CODES({RX_AACK_CODE, RX_ON_CODE})
  ) u_guard (
    .clk(clk), .rst(rst), .safe_en(cfg_rdata[B_SAFE]), .frame_ok(rx_frame_ok),
    .state(trx_state), .rd_active(buf_read), .sel_n(spi_sel_n), .locked(buf_locked)
  );

  assign is_oqpsk   = mode_q.oqpsk;
  assign chip_kcps  = mode_q.chip;
  assign rate_kbps  = mode_q.rate;
  assign shape_sel  = mode_q.shape;
  assign alt_spread = mode_q.alt_spread;
  assign scram_on   = mode_q.scram;
  assign mode_ok    = mode_q.valid;
  assign reg_hold   = mode_q.hold;
endmodule

// File: rtl/phy_mode_ctrl_chk.sv
module phy_mode_ctrl_chk #(
  parameter int                 STATE_W      = 5,
  parameter logic [STATE_W-1:0] RX_ON_CODE   = 5'h06,
  parameter logic [STATE_W-1:0] RX_AACK_CODE = 5'h16
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic [7:0]         cfg_wdata,
  input logic [7:0]         cfg_rdata,
  input logic               rx_frame_ok,
  input logic [STATE_W-1:0] trx_state,
  input logic               buf_read,
  input logic               spi_sel_n,
  input logic               is_oqpsk,
  input logic [10:0]        chip_kcps,
  input logic [10:0]        rate_kbps,
  input logic [2:0]         shape_sel,
  input logic               alt_spread,
  input logic               scram_on,
  input logic               mode_ok,
  input logic               buf_locked
);
  logic               c_sel_prev;
  logic [STATE_W-1:0] c_state_prev;
  logic               c_rise_rd, c_leave;

  always_ff @(posedge clk) begin
    c_sel_prev   <= spi_sel_n;
    c_state_prev <= trx_state;
  end

  assign c_rise_rd = spi_sel_n && !c_sel_prev && buf_read;
  assign c_leave   = ((c_state_prev == RX_ON_CODE) || (c_state_prev == RX_AACK_CODE))
                     && (trx_state != c_state_prev);

  // R1
  p_reset_val_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cfg_rdata == 8'h14);
  // R2
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));
  // R3
  p_chip_r3: assert property (@(posedge clk) disable iff (rst)
    is_oqpsk |-> (chip_kcps == 11'd400 || chip_kcps == 11'd1000));
  // R5
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[3] && !cfg_rdata[2] && cfg_rdata[1:0] == 2'b11) |=> !mode_ok);
  p_legal_r5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_rdata[3] && !cfg_rdata[2] && cfg_rdata[1:0] == 2'b11) |=> mode_ok);
  // R6
  p_scram_r6: assert property (@(posedge clk) disable iff (rst)
    scram_on |-> is_oqpsk && (rate_kbps == 11'd400 || rate_kbps == 11'd1000));
  // R7
  p_alt_r7: assert property (@(posedge clk) disable iff (rst)
    alt_spread |-> !is_oqpsk && shape_sel == 3'd0);
  // R8
  p_lock_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7] && rx_frame_ok && !c_rise_rd && !c_leave) |=> buf_locked);
  // R9
  p_sel_clear_r9: assert property (@(posedge clk) disable iff (rst)
    c_rise_rd |=> !buf_locked);
  p_sel_noread_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(spi_sel_n) && !buf_read && buf_locked && cfg_rdata[7] && !c_leave) |=> buf_locked);
  // R10
  p_leave_rx_r10: assert property (@(posedge clk) disable iff (rst)
    c_leave |=> !buf_locked);
  // R11
  p_safe_off_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[7] |=> !buf_locked);
endmodule

bind phy_mode_ctrl phy_mode_ctrl_chk #(
  .STATE_W(STATE_W), .RX_ON_CODE(RX_ON_CODE), .RX_AACK_CODE(RX_AACK_CODE)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .rx_frame_ok(rx_frame_ok), .trx_state(trx_state), .buf_read(buf_read),
  .spi_sel_n(spi_sel_n), .is_oqpsk(is_oqpsk), .chip_kcps(chip_kcps),
  .rate_kbps(rate_kbps), .shape_sel(shape_sel), .alt_spread(alt_spread),
  .scram_on(scram_on), .mode_ok(mode_ok), .buf_locked(buf_locked)
);

// File: tb/phy_mode_ctrl_bench.sv
module phy_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        rx_frame_ok = 1'b0;
  logic [4:0]  trx_state = 5'h08;
  logic        buf_read = 1'b0;
  logic        spi_sel_n = 1'b1;
  logic        is_oqpsk, alt_spread, scram_on, mode_ok, reg_hold, buf_locked;
  logic [10:0] chip_kcps, rate_kbps;
  logic [2:0]  shape_sel;

  always #10 clk = ~clk;

  phy_mode_ctrl u_phy_mode_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_frame_ok(rx_frame_ok), .trx_state(trx_state), .buf_read(buf_read),
    .spi_sel_n(spi_sel_n), .is_oqpsk(is_oqpsk), .chip_kcps(chip_kcps),
    .rate_kbps(rate_kbps), .shape_sel(shape_sel), .alt_spread(alt_spread),
    .scram_on(scram_on), .mode_ok(mode_ok), .reg_hold(reg_hold), .buf_locked(buf_locked)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  task automatic cmp(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference
  int   hi_tab[4] = '{250, 500, 1000, 500};
  int   lo_tab[4] = '{100, 200, 400, 0};
  logic [7:0] m_cfg;
  int   m_chip, m_rate, m_shape;
  bit   m_oq, m_alt, m_scr, m_ok, m_hold, m_lock;
  logic m_sel_prev;
  logic [4:0] m_st_prev;

  task automatic model_decode(input logic [7:0] c);
    bit oq, hi, alt;
    int code;
    oq = c[3]; hi = c[2]; alt = c[4]; code = int'(c[1:0]);
    m_oq   = oq;
    m_chip = oq ? (hi ? 1000 : 400) : (hi ? 600 : 300);
    m_rate = oq ? (hi ? hi_tab[code] : lo_tab[code]) : (hi ? 40 : 20);
    if (!oq) m_shape = 0;
    else     m_shape = hi ? (alt ? 2 : 1) : (alt ? 4 : 3);
    m_alt  = !oq && alt;
    m_scr  = c[5] && oq && (m_rate == 400 || m_rate == 1000);
    m_ok   = !(oq && !hi && code == 3);
    m_hold = c[6];
  endtask

  always @(posedge clk) begin
    bit clr;
    if (rst) begin
      m_cfg  = 8'h14;
      m_lock = 0;
      model_decode(8'h14);
    end else begin
      model_decode(m_cfg);
      clr = (spi_sel_n && !m_sel_prev && buf_read)
         || ((m_st_prev == 5'h06 || m_st_prev == 5'h16) && trx_state != m_st_prev)
         || !m_cfg[7];
      if (clr) m_lock = 0;
      else if (rx_frame_ok) m_lock = 1;
      if (cfg_wr) m_cfg = cfg_wdata;
    end
    m_sel_prev = spi_sel_n;
    m_st_prev  = trx_state;
    cmp_on     = 1;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      cmp("R2 cfg_rdata",  int'(cfg_rdata),  int'(m_cfg));
      cmp("R3 chip_kcps",  int'(chip_kcps),  m_chip);
      cmp("R3 is_oqpsk",   int'(is_oqpsk),   int'(m_oq));
      cmp("R4 rate_kbps",  int'(rate_kbps),  m_rate);
      cmp("R5 mode_ok",    int'(mode_ok),    int'(m_ok));
      cmp("R6 scram_on",   int'(scram_on),   int'(m_scr));
      cmp("R7 shape_sel",  int'(shape_sel),  m_shape);
      cmp("R7 alt_spread", int'(alt_spread), int'(m_alt));
      cmp("R12 reg_hold",  int'(reg_hold),   int'(m_hold));
      cmp("R8 R9 R10 R11 buf_locked", int'(buf_locked), int'(m_lock));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); rx_frame_ok = 1'b1;
    @(negedge clk); rx_frame_ok = 1'b0;
  endtask

  task automatic sel_pulse(input logic rd);
    @(negedge clk); spi_sel_n = 1'b0; buf_read = rd;
    @(negedge clk); spi_sel_n = 1'b1;
    @(negedge clk); buf_read = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset setting
    cmp("R1 reset value", int'(cfg_rdata), 8'h14);
    cmp("R1 reset chip",  int'(chip_kcps), 600);
    cmp("R1 reset rate",  int'(rate_kbps), 40);
    cmp("R1 reset lock",  int'(buf_locked), 0);

    // R2..R7, R12: sweep every register value
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      cyc(1);
    end

    // R5: reserved O-QPSK low-band code 3
    wr(8'h0B); cyc(1);
    cmp("R5 reserved mode_ok", int'(mode_ok), 0);
    // R6: scrambler at 1000 kb/s
    wr(8'h2E); cyc(1);
    cmp("R6 scram 1000", int'(scram_on), 1);
    cmp("R3 chip 1000",  int'(chip_kcps), 1000);
    // R6: scrambler request ignored at 500 kb/s
    wr(8'h2D); cyc(1);
    cmp("R6 scram off 500", int'(scram_on), 0);
    // R7: RC-0.8 shaping
    wr(8'h1E); cyc(1);
    cmp("R7 shape rc08", int'(shape_sel), 2);
    // R4: BPSK ignores the rate code
    wr(8'h07); cyc(1);
    cmp("R4 bpsk rate", int'(rate_kbps), 40);

    // R8: frames with safe-receive clear do nothing
    wr(8'h14); frame(); cyc(1);
    cmp("R8 no lock when safe off", int'(buf_locked), 0);
    // R8: lock on good frame, held through a second one
    wr(8'h94); frame();
    cmp("R8 lock set", int'(buf_locked), 1);
    frame(); cyc(1);
    cmp("R8 lock held", int'(buf_locked), 1);
    // R9: select rise without a read leaves the lock
    sel_pulse(1'b0);
    cmp("R9 no read keeps lock", int'(buf_locked), 1);
    // R9: select rise ending a read clears
    sel_pulse(1'b1);
    cmp("R9 read end clears", int'(buf_locked), 0);

    // R10: leaving listen state clears
    @(negedge clk); trx_state = 5'h06;
    frame(); cyc(1);
    cmp("R10 lock in listen", int'(buf_locked), 1);
    @(negedge clk); trx_state = 5'h08;
    @(negedge clk);
    cmp("R10 leave listen clears", int'(buf_locked), 0);
    // R10: leaving the acknowledge listen state clears
    @(negedge clk); trx_state = 5'h16;
    frame(); cyc(1);
    @(negedge clk); trx_state = 5'h09;
    @(negedge clk);
    cmp("R10 leave ack listen clears", int'(buf_locked), 0);

    // R11: clear and set in the same cycle
    @(negedge clk); spi_sel_n = 1'b0; buf_read = 1'b1;
    @(negedge clk); spi_sel_n = 1'b1; rx_frame_ok = 1'b1;
    @(negedge clk); rx_frame_ok = 1'b0; buf_read = 1'b0;
    cmp("R11 clear wins over sel", int'(buf_locked), 0);
    @(negedge clk); trx_state = 5'h06;
    cyc(2);
    @(negedge clk); trx_state = 5'h08; rx_frame_ok = 1'b1;
    @(negedge clk); rx_frame_ok = 1'b0;
    cmp("R11 clear wins over leave", int'(buf_locked), 0);
    // R11: dropping safe-receive clears the lock
    frame();
    cmp("R11 relock", int'(buf_locked), 1);
    wr(8'h14); cyc(1);
    cmp("R11 safe off clears", int'(buf_locked), 0);
    // R12: regulator hold bit
    wr(8'h54); cyc(1);
    cmp("R12 reg_hold", int'(reg_hold), 1);

    cyc(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule